// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two eight-bit buses, called A and B, through a pair of one-bit-per-channel storage registers, one for each direction. The A-to-B register is loaded from bus A on every rising edge of its own capture clock. The B-to-A register is loaded from bus B on every rising edge of a second, independent clock. Capture never stops. The output enables and the selects only decide what each side drives. For each direction a select picks what appears on the far bus: either the live value of the opposite bus or the stored register contents. Whatever is driven is the bitwise inverse of the chosen value.

The tri-state pins are split into an input vector, an output vector and an output-enable vector for each side. A system wrapper turns these into real pads. When a side drives its own bus, the registers sample the block's own driven value on that bus, not the external input. This gives the "load both registers from one bus" and "copy one register into the other" modes. With both sides driving and both selects on live data, the two live paths would form a combinational loop. The block breaks that loop by driving stored data on both sides, and it raises an illegal-mode flag. All pins carry levels, not transfers, so no port uses a valid/ready handshake and there is no back-pressure.

Top module: `bireg_xcvr`

## Requirements
- R1: While `rst_n` is low, both registers clear to zero and `illegal` is 0. After reset, stored mode on either side shows 8'hFF.
- R2: A rising `clk_ab` loads the current bus-A value into the A-to-B register. A rising `clk_ba` loads the current bus-B value into the B-to-A register. Enables and selects do not gate capture.
- R3: The bus value a register samples is the side's external input (`a_in`/`b_in`) when that side is not driven. When the side is driven, it is the block's own driven value (`a_out`/`b_out`). So with `b_en`=1 and `sel_ab`=0, a `clk_ba` edge stores the inverse of bus A.
- R4: With side B enabled, `sel_ab`=0 drives `b_out` = ~(bus-A value) and `sel_ab`=1 drives `b_out` = ~(A-to-B register). The same holds for `a_out` with `sel_ba` and the B-to-A register. (This excludes the loop case of R8.)
- R5: Side B is enabled when `b_en`=1. Side A is enabled when `a_en_n`=0. An enabled side has its oe vector all ones. A disabled side has its oe vector and its data output all zeros.
- R6: With both sides disabled (`b_en`=0, `a_en_n`=1), neither side is driven and both registers still capture their external inputs.
- R7: When both clocks rise on the same edge, each register takes the bus value from before that edge. With a select high, the opposite register therefore receives the inverse of the old stored value.
- R8: When both sides are enabled and both selects are 0, `b_out` = ~(A-to-B register), `a_out` = ~(B-to-A register), and `illegal` is 1 in that same cycle.
- R9: A rising edge of either clock while the R8 condition holds sets `illegal` so that it stays 1 until reset. Without such an edge, `illegal` falls when the condition ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low reset, for initialisation |
| a_in | input | 8 | Value applied to bus A from outside |
| b_in | input | 8 | Value applied to bus B from outside |
| b_en | input | 1 | Active-high enable for driving side B |
| a_en_n | input | 1 | Active-low enable for driving side A |
| sel_ab | input | 1 | Source for side B: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | Source for side A: 0 live B, 1 stored B-to-A |
| a_out | output | 8 | Data driven onto bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_out | output | 8 | Data driven onto bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |
| illegal | output | 1 | Illegal-mode flag, live plus sticky |

## Verification
The clocked assertions sample the control and data inputs at clock edges. They assume these inputs are steady around every rising edge of either clock, because the block has no synchroniser and two clocks that are unrelated in phase. The stimulus therefore changes every input only while both clocks are low. It then raises one clock, the other, or both together for half a period before the next change. This means the simultaneous-edge case of R7 is always a clean coincidence, never a near miss.

// File: rtl/bireg_pkg.sv
package bireg_pkg;
  localparam int unsigned BIREG_DEF_W = 8;

  // What one side puts on its bus.
  typedef enum logic [1:0] {
    SRC_OFF      = 2'd0, // side not driven
    SRC_LIVE_EXT = 2'd1, // live value taken from the far side's external input
    SRC_LIVE_OWN = 2'd2, // live value taken from the far side's own stored drive
    SRC_STORED   = 2'd3  // this direction's register
  } bireg_src_e;
endpackage

// File: rtl/bireg_capture.sv
module bireg_capture #(
  parameter int unsigned W = bireg_pkg::BIREG_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (q == $past(d)))
    else $error("capture register missed its bus value"); // R2
endmodule

// File: rtl/bireg_drive.sv
module bireg_drive
  import bireg_pkg::*;
#(
  parameter int unsigned W = BIREG_DEF_W
) (
  input  bireg_src_e   src,
  input  logic [W-1:0] ext_in,  // external input of the far bus
  input  logic [W-1:0] own_q,   // register of this direction
  input  logic [W-1:0] far_q,   // register of the opposite direction
  output logic [W-1:0] drv,
  output logic [W-1:0] oe
);
  // When the far side is itself driven from its register, its bus carries
  // ~far_q; inverting that again yields far_q, with no path through drv.
  always_comb begin
    unique case (src)
      SRC_LIVE_EXT: drv = ~ext_in;
      SRC_LIVE_OWN: drv = far_q;
      SRC_STORED:   drv = ~own_q;
      default:      drv = '0;
    endcase
    oe = (src == SRC_OFF) ? '0 : '1;
  end
endmodule

// File: rtl/bireg_ctrl.sv
module bireg_ctrl
  import bireg_pkg::*;
(
  input  logic       clk_ab,
  input  logic       clk_ba,
  input  logic       rst_n,
  input  logic       b_en,
  input  logic       a_en_n,
  input  logic       sel_ab,
  input  logic       sel_ba,
  output bireg_src_e src_a,
  output bireg_src_e src_b,
  output logic       en_a,
  output logic       en_b,
  output logic       illegal
);
  logic loop_now;
  logic seen_ab, seen_ba;

  always_comb begin
    en_a     = ~a_en_n;
    en_b     = b_en;
    loop_now = en_a & en_b & ~sel_ab & ~sel_ba;

    if (!en_b)                 src_b = SRC_OFF;
    else if (sel_ab || loop_now) src_b = SRC_STORED;
    else if (en_a)             src_b = SRC_LIVE_OWN;
    else                       src_b = SRC_LIVE_EXT;

    if (!en_a)                 src_a = SRC_OFF;
    else if (sel_ba || loop_now) src_a = SRC_STORED;
    else if (en_b)             src_a = SRC_LIVE_OWN;
    else                       src_a = SRC_LIVE_EXT;
  end

  // One sticky bit per clock domain; each is set only by its own clock.
  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n)        seen_ab <= 1'b0;
    else if (loop_now) seen_ab <= 1'b1;
  end

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n)        seen_ba <= 1'b0;
    else if (loop_now) seen_ba <= 1'b1;
  end

  assign illegal = loop_now | seen_ab | seen_ba;

  AST_ILLEGAL_HOLDS: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (seen_ab || seen_ba) |=> illegal)
    else $error("illegal flag dropped"); // R9

  AST_SRC_EXCLUSIVE: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (src_a == SRC_LIVE_OWN) |-> (src_b == SRC_STORED))
    else $error("live path from a driven side not backed by storage"); // R8
endmodule

// File: rtl/bireg_xcvr.sv
module bireg_xcvr
  import bireg_pkg::*;
#(
  parameter int unsigned W = BIREG_DEF_W
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         b_en,
  input  logic         a_en_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         illegal
);
  bireg_src_e   src_a, src_b;
  logic         en_a, en_b;
  logic [W-1:0] q_ab, q_ba;
  logic [W-1:0] bus_a, bus_b;

  bireg_ctrl u_ctrl (
    .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
    .b_en (b_en), .a_en_n (a_en_n), .sel_ab (sel_ab), .sel_ba (sel_ba),
    .src_a (src_a), .src_b (src_b), .en_a (en_a), .en_b (en_b),
    .illegal (illegal)
  );

  bireg_drive #(.W(W)) u_drv_b (
    .src (src_b), .ext_in (a_in), .own_q (q_ab), .far_q (q_ba),
    .drv (b_out), .oe (b_oe)
  );

  bireg_drive #(.W(W)) u_drv_a (
    .src (src_a), .ext_in (b_in), .own_q (q_ba), .far_q (q_ab),
    .drv (a_out), .oe (a_oe)
  );

  // Resolved bus values as the registers see them.
  assign bus_a = en_a ? a_out : a_in;
  assign bus_b = en_b ? b_out : b_in;

  bireg_capture #(.W(W)) u_reg_ab (
    .clk (clk_ab), .rst_n (rst_n), .d (bus_a), .q (q_ab)
  );

  bireg_capture #(.W(W)) u_reg_ba (
    .clk (clk_ba), .rst_n (rst_n), .d (bus_b), .q (q_ba)
  );

  AST_STORED_B: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_en && sel_ab) |-> (b_out == ~q_ab))
    else $error("stored A data not on side B"); // R4

  AST_STORED_A: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!a_en_n && sel_ba) |-> (a_out == ~q_ba))
    else $error("stored B data not on side A"); // R4

  AST_LIVE_B: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_en && !sel_ab && a_en_n) |-> (b_out == ~a_in))
    else $error("live A data not on side B"); // R4

  AST_ISOLATION: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_en_n && !b_en) |-> ((a_oe == '0) && (b_oe == '0)))
    else $error("side driven in isolation"); // R6

  AST_LOOP_FALLBACK: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_en && !a_en_n && !sel_ab && !sel_ba)
      |-> ((a_out == ~q_ba) && (b_out == ~q_ab) && illegal))
    else $error("loop mode not broken or not flagged"); // R8
endmodule

// File: tb/bireg_xcvr_bench.sv
module bireg_xcvr_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk_ab, clk_ba, rst_n;
  logic [W-1:0] a_in, b_in;
  logic b_en, a_en_n, sel_ab, sel_ba;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic illegal;

  int total = 0;
  int bad = 0;

  bireg_xcvr #(.W(W)) u_bireg_xcvr (
    .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
    .a_in (a_in), .b_in (b_in), .b_en (b_en), .a_en_n (a_en_n),
    .sel_ab (sel_ab), .sel_ba (sel_ba),
    .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe),
    .illegal (illegal)
  );

  // Reference model state and results.
  logic [W-1:0] m_ab, m_ba;
  logic         m_flag;
  logic [W-1:0] e_a, e_b, e_aoe, e_boe, e_abus, e_bbus;
  logic         e_loop;

  function automatic void model_eval();
    logic ea, eb;
    ea = !a_en_n;
    eb = b_en;
    e_loop = ea && eb && !sel_ab && !sel_ba;
    e_a = '0;
    e_b = '0;
    if (e_loop) begin
      e_a = ~m_ba;
      e_b = ~m_ab;
    end else begin
      if (eb && sel_ab) e_b = ~m_ab;
      if (ea && sel_ba) e_a = ~m_ba;
      if (ea && !sel_ba) e_a = ~(eb ? e_b : b_in);
      if (eb && !sel_ab) e_b = ~(ea ? e_a : a_in);
    end
    e_aoe  = ea ? '1 : '0;
    e_boe  = eb ? '1 : '0;
    e_abus = ea ? e_a : a_in;
    e_bbus = eb ? e_b : b_in;
  endfunction

  function automatic void cmp(input string tag, input string what,
                              input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  function automatic void check_all(input string tag);
    model_eval();
    cmp(tag, "a_out", a_out, e_a);
    cmp(tag, "b_out", b_out, e_b);
    cmp(tag, "a_oe", a_oe, e_aoe);
    cmp(tag, "b_oe", b_oe, e_boe);
    cmp(tag, "illegal", {{(W-1){1'b0}}, illegal}, {{(W-1){1'b0}}, e_loop | m_flag});
  endfunction

  task automatic step(input string tag, input logic [W-1:0] ai, input logic [W-1:0] bi,
                      input logic ben, input logic aenn, input logic sab, input logic sba,
                      input logic pab, input logic pba);
    logic [W-1:0] nab, nba;
    logic lp;
    a_in = ai; b_in = bi; b_en = ben; a_en_n = aenn; sel_ab = sab; sel_ba = sba;
    #2;
    check_all(tag);
    nab = e_abus;
    nba = e_bbus;
    lp  = e_loop;
    clk_ab = pab;
    clk_ba = pba;
    #(HALF);
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    if (pab) m_ab = nab;
    if (pba) m_ba = nba;
    if ((pab || pba) && lp) m_flag = 1'b1;
    #(HALF - 2);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clk_ab = 0; clk_ba = 0; rst_n = 0;
    a_in = '0; b_in = '0; b_en = 0; a_en_n = 1; sel_ab = 0; sel_ba = 0;
    m_ab = '0; m_ba = '0; m_flag = 0;
    #7;
    rst_n = 1;
    #3;

    // R1: stored mode on both sides shows ~0 after reset, flag clear
    step("R1", 8'h12, 8'h34, 1, 0, 1, 1, 0, 0);

    // R6: isolation, both registers still capture external inputs
    step("R6", 8'h5A, 8'hC3, 0, 1, 0, 0, 1, 1);
    // R2: read captured values back through stored modes
    step("R2", 8'h00, 8'h00, 1, 1, 1, 0, 0, 0);
    step("R2", 8'h00, 8'h00, 0, 0, 0, 1, 0, 0);
    step("R5", 8'hFF, 8'h81, 0, 1, 1, 1, 0, 0);

    // R4: live A to B, then live B to A, with inversion
    step("R4", 8'h96, 8'h00, 1, 1, 0, 0, 0, 0);
    step("R4", 8'h00, 8'h69, 0, 0, 0, 0, 0, 0);

    // R3: store A in both (B driven live from A, both clocks)
    step("R3", 8'h3C, 8'hEE, 1, 1, 0, 0, 1, 1);
    step("R3", 8'h00, 8'h00, 1, 0, 1, 1, 0, 0);
    // R3: store B in both
    step("R3", 8'h11, 8'hA7, 0, 0, 0, 0, 1, 1);
    step("R3", 8'h00, 8'h00, 1, 0, 1, 1, 0, 0);

    // R7: simultaneous edges with a select high: B-to-A gets old ~q_ab
    step("R7", 8'h0F, 8'h00, 1, 1, 1, 0, 1, 1);
    step("R7", 8'h00, 8'h00, 1, 0, 1, 1, 0, 0);
    // R2: capture of a side's own stored drive (A driven from storage)
    step("R2", 8'hF0, 8'h00, 0, 0, 0, 1, 1, 0);
    step("R2", 8'h00, 8'h00, 1, 0, 1, 1, 0, 0);

    // R8: loop without edge: fallback, flag live, then drops
    step("R8", 8'h77, 8'h88, 1, 0, 0, 0, 0, 0);
    step("R9", 8'h77, 8'h88, 1, 0, 1, 1, 0, 0);
    // R9: loop during an edge makes the flag sticky
    step("R9", 8'h24, 8'h42, 1, 0, 0, 0, 1, 0);
    step("R9", 8'h24, 8'h42, 0, 1, 0, 0, 0, 0);

    // Random mix of all modes and clock patterns
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      logic [1:0] k;
      c = 4'($urandom);
      k = 2'($urandom);
      step("R4", 8'($urandom), 8'($urandom), c[0], c[1], c[2], c[3], k[0], k[1]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule